// File: doc/BRIEF.md
# Host Pipe Control and Interrupt-Enable Register Bank

This block holds the control and interrupt-enable word of every pipe in a USB host controller that serves interrupt pipes. Software never writes a pipe's word directly. It writes ones into a set alias or a clear alias, and only the bits written as one change. The word is read back through a read view. Each pipe also takes hardware events from the packet engine. Some of these freeze the pipe on their own. One of them hands the current FIFO bank to software.

Each pipe runs a two-state bank handshake. In `FC_WAIT` the FIFO-control bit is low and the pipe waits for hardware. The transition `BANK_GRANT` happens on a bank event: the current bank has become free (OUT/SETUP) or has been filled (IN). It moves the pipe to `FC_OWNED` and raises the FIFO-control bit. The transition `BANK_RELEASE` happens when software clears that bit. It returns the pipe to `FC_WAIT`, strobes a bank switch and flips the bank pointer.

The block also drives these outputs:
- a one-cycle data-toggle reset pulse for each pipe;
- a freeze level for each pipe;
- an interrupt line for each pipe, built from its enabled status flags;
- one summary interrupt.

Top module: `hpb_ctl_bank`

## Requirements
- R1: After reset, every pipe word reads 0. `toggle_rst`, `pipe_frozen`, `bank_switch`, `bank_sel`, `pipe_irq` and `irq` are all 0, provided `cfg_ok` is high and the pipe-reset and pipe-enable inputs are low.
- R2: The byte address selects a region in bits [7:6] and a pipe in bits [5:2].
  - Region 0 is the read view, region 1 the set alias and region 2 the clear alias.
  - `bus_rdata` shows the word of the addressed pipe in any region.
  - A pipe index of 10 or more reads 0, and writes to it are ignored.
  - Region 3 writes and writes with bits [1:0] non-zero are ignored.
- R3: A write to the set alias sets each of bits 0–7 (status enables), 12 (busy-bank enable), 16 (DMA-request disable), 17 (freeze) and 18 (toggle reset) that is written as 1. Bits written as 0 keep their value.
- R4: A write to the clear alias clears each of bits 0–7, 12, 14, 16 and 17 that is written as 1. Bits written as 0 keep their value. Writes to the read view change nothing, and bits 8–11, 13, 15 and 19–31 always read 0.
- R5: When `pipe_is_int[n]` is 0 (the pipe is not an interrupt pipe), software writes to pipe n have no effect.
- R6: Each of these sets freeze (bit 17) at the next edge: `cfg_ok` low, `stall_evt`, `err_flag`, `quota_done`. Only a clear-alias write removes freeze. If a clear and a hardware condition arrive in the same cycle, the pipe stays frozen.
- R7: A rising edge of `pipe_rst` or of `pipe_en` freezes the pipe. Holding either input high afterwards does not freeze the pipe again.
- R8: Setting bit 18 drives `toggle_rst[n]` and bit 18 high for exactly one cycle. Both then return to 0 on their own.
- R9: `bank_evt[n]` in `FC_WAIT` (`BANK_GRANT`) sets bit 14 at the next edge. Writing bit 14 through the set alias has no effect.
- R10: Clearing bit 14 in `FC_OWNED` (`BANK_RELEASE`) pulses `bank_switch[n]` for one cycle and flips `bank_sel[n]` at the same edge.
  - Clearing it in `FC_WAIT` gives no strobe.
  - A clear that coincides with `bank_evt` leaves the pipe in `FC_OWNED` with no strobe.
- R11: Each pipe has 9 status flags. Flag bit k (k = 0..7) pairs with enable bit k, and flag bit 8 pairs with enable bit 12. `pipe_irq[n]` is high when any flag is high together with its enable. `irq` is the OR of all `pipe_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Word of the addressed pipe |
| pipe_is_int | input | 10 | Pipe type is interrupt; gates software writes |
| cfg_ok | input | 10 | Pipe configured |
| stall_evt | input | 10 | STALL handshake received |
| err_flag | input | 10 | Pipe error flag |
| quota_done | input | 10 | All requested IN transactions done |
| pipe_rst | input | 10 | Pipe reset level |
| pipe_en | input | 10 | Pipe enable level |
| bank_evt | input | 10 | Current bank freed (OUT) or filled (IN) |
| stat_flags | input | 90 | Status flags, 9 per pipe, pipe n at [9n +: 9] |
| toggle_rst | output | 10 | Data-toggle reset pulse |
| pipe_frozen | output | 10 | Pipe freeze level |
| bank_switch | output | 10 | Bank switch strobe |
| bank_sel | output | 10 | Current bank pointer |
| pipe_irq | output | 10 | Per-pipe interrupt |
| irq | output | 1 | Summary interrupt |

## Verification
The embedded assertions check these properties on every cycle of any run:
- the toggle pulse lasts one cycle;
- any hardware freeze condition leads to freeze on the next cycle;
- a bank grant raises the FIFO-control bit;
- a strobe coincides with a return to `FC_WAIT` and a pointer flip;
- enables do not move without a write.

Only the bench scenarios can show the following:
- the address map and the rejection of out-of-range, misaligned and region-3 writes;
- write gating by pipe type;
- edge-only (not level) freezing;
- the conflict outcomes for freeze and for bank release;
- the interrupt combination.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
    localparam int WORD_W   = 32;
    localparam int NSTAT    = 9;
    localparam int B_BUSY   = 12;
    localparam int B_FIFO   = 14;
    localparam int B_DMA    = 16;
    localparam int B_FRZ    = 17;
    localparam int B_TGL    = 18;
    localparam logic [WORD_W-1:0] SET_OK = 32'h0007_10FF;
    localparam logic [WORD_W-1:0] CLR_OK = 32'h0003_50FF;

    typedef enum logic {
        FC_WAIT  = 1'b0,
        FC_OWNED = 1'b1
    } fc_state_t;
endpackage

// File: rtl/hpb_decode.sv
module hpb_decode
    import hpb_pkg::*;
#(
    parameter int NPIPE  = 10,
    parameter int ADDR_W = 8
) (
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    input  logic [NPIPE-1:0]        pipe_is_int,
    input  logic [NPIPE*WORD_W-1:0] words,
    output logic [NPIPE*WORD_W-1:0] set_bits,
    output logic [NPIPE*WORD_W-1:0] clr_bits,
    output logic [WORD_W-1:0]       bus_rdata
);
    localparam int IDX_W = ADDR_W - 4;

    logic [1:0]       region;
    logic [IDX_W-1:0] idx;
    logic             aligned;

    assign region  = bus_addr[ADDR_W-1 -: 2];
    assign idx     = bus_addr[ADDR_W-3:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    for (genvar i = 0; i < NPIPE; i++) begin : g_dec
        logic hit;
        assign hit = bus_wr && aligned && pipe_is_int[i] && (idx == IDX_W'(i));
        assign set_bits[i*WORD_W +: WORD_W] = (hit && region == 2'd1) ? (bus_wdata & SET_OK) : '0;
        assign clr_bits[i*WORD_W +: WORD_W] = (hit && region == 2'd2) ? (bus_wdata & CLR_OK) : '0;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NPIPE; i++) begin
            if (idx == IDX_W'(i)) bus_rdata = words[i*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/hpb_pipe.sv
module hpb_pipe
    import hpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] sw_set,
    input  logic [WORD_W-1:0] sw_clr,
    input  logic              cfg_ok,
    input  logic              stall_evt,
    input  logic              err_flag,
    input  logic              quota_done,
    input  logic              pipe_rst,
    input  logic              pipe_en,
    input  logic              bank_evt,
    input  logic [NSTAT-1:0]  stat,
    output logic [WORD_W-1:0] word_q,
    output logic              toggle_rst,
    output logic              frozen,
    output logic              bank_switch,
    output logic              bank_sel,
    output logic              pipe_irq
);
    fc_state_t  fc_q, fc_d;
    logic [7:0] en_q;
    logic       busy_en_q, dma_dis_q, frz_q, tgl_q;
    logic       rst_prev, en_prev, hw_frz, release_now;

    logic unused_bits;
    assign unused_bits = ^{sw_set[31:19], sw_set[15:13], sw_set[11:8],
                           sw_clr[31:18], sw_clr[15], sw_clr[13], sw_clr[11:8]};

    assign hw_frz = !cfg_ok || stall_evt || err_flag || quota_done ||
                    (pipe_rst && !rst_prev) || (pipe_en && !en_prev);

    // Bank handshake: state register
    always_ff @(posedge clk) begin
        if (!rst_n) fc_q <= FC_WAIT;
        else        fc_q <= fc_d;
    end

    // Bank handshake: next state (BANK_GRANT, BANK_RELEASE)
    always_comb begin
        fc_d = fc_q;
        unique case (fc_q)
            FC_WAIT:  if (bank_evt) fc_d = FC_OWNED;
            FC_OWNED: if (sw_clr[B_FIFO] && !bank_evt) fc_d = FC_WAIT;
            default:  fc_d = FC_WAIT;
        endcase
    end

    assign release_now = (fc_q == FC_OWNED) && (fc_d == FC_WAIT);

    // Bank handshake: outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_switch <= 1'b0;
            bank_sel    <= 1'b0;
        end else begin
            bank_switch <= release_now;
            if (release_now) bank_sel <= !bank_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= '0;
            busy_en_q <= 1'b0;
            dma_dis_q <= 1'b0;
            frz_q     <= 1'b0;
            tgl_q     <= 1'b0;
            rst_prev  <= 1'b0;
            en_prev   <= 1'b0;
        end else begin
            en_q      <= (en_q | sw_set[7:0]) & ~sw_clr[7:0];
            busy_en_q <= (busy_en_q | sw_set[B_BUSY]) & ~sw_clr[B_BUSY];
            dma_dis_q <= (dma_dis_q | sw_set[B_DMA]) & ~sw_clr[B_DMA];
            frz_q     <= hw_frz || sw_set[B_FRZ] || (frz_q && !sw_clr[B_FRZ]);
            tgl_q     <= sw_set[B_TGL] && !tgl_q;
            rst_prev  <= pipe_rst;
            en_prev   <= pipe_en;
        end
    end

    assign word_q = {13'b0, tgl_q, frz_q, dma_dis_q, 1'b0, (fc_q == FC_OWNED),
                     1'b0, busy_en_q, 4'b0, en_q};
    assign toggle_rst = tgl_q;
    assign frozen     = frz_q;
    assign pipe_irq   = (|(stat[7:0] & en_q)) || (stat[8] && busy_en_q);

    a_r8_toggle_single: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_rst |=> !toggle_rst);
    a_r6_hw_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        hw_frz |=> frozen);
    a_r9_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_evt && fc_q == FC_WAIT) |=> word_q[B_FIFO]);
    a_r10_switch_wait: assert property (@(posedge clk) disable iff (!rst_n)
        bank_switch |-> (fc_q == FC_WAIT) && (bank_sel != $past(bank_sel)));
    a_r4_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set[7:0] == 8'h00 && sw_clr[7:0] == 8'h00) |=> $stable(word_q[7:0]));
endmodule

// File: rtl/hpb_ctl_bank.sv
module hpb_ctl_bank
    import hpb_pkg::*;
#(
    parameter int NPIPE  = 10,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [WORD_W-1:0]      bus_wdata,
    output logic [WORD_W-1:0]      bus_rdata,
    input  logic [NPIPE-1:0]       pipe_is_int,
    input  logic [NPIPE-1:0]       cfg_ok,
    input  logic [NPIPE-1:0]       stall_evt,
    input  logic [NPIPE-1:0]       err_flag,
    input  logic [NPIPE-1:0]       quota_done,
    input  logic [NPIPE-1:0]       pipe_rst,
    input  logic [NPIPE-1:0]       pipe_en,
    input  logic [NPIPE-1:0]       bank_evt,
    input  logic [NPIPE*NSTAT-1:0] stat_flags,
    output logic [NPIPE-1:0]       toggle_rst,
    output logic [NPIPE-1:0]       pipe_frozen,
    output logic [NPIPE-1:0]       bank_switch,
    output logic [NPIPE-1:0]       bank_sel,
    output logic [NPIPE-1:0]       pipe_irq,
    output logic                   irq
);
    logic [NPIPE*WORD_W-1:0] words, set_bits, clr_bits;

    hpb_decode #(.NPIPE(NPIPE), .ADDR_W(ADDR_W)) u_dec (
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .pipe_is_int (pipe_is_int),
        .words       (words),
        .set_bits    (set_bits),
        .clr_bits    (clr_bits),
        .bus_rdata   (bus_rdata)
    );

    for (genvar i = 0; i < NPIPE; i++) begin : g_pipe
        hpb_pipe u_pipe (
            .clk         (clk),
            .rst_n       (rst_n),
            .sw_set      (set_bits[i*WORD_W +: WORD_W]),
            .sw_clr      (clr_bits[i*WORD_W +: WORD_W]),
            .cfg_ok      (cfg_ok[i]),
            .stall_evt   (stall_evt[i]),
            .err_flag    (err_flag[i]),
            .quota_done  (quota_done[i]),
            .pipe_rst    (pipe_rst[i]),
            .pipe_en     (pipe_en[i]),
            .bank_evt    (bank_evt[i]),
            .stat        (stat_flags[i*NSTAT +: NSTAT]),
            .word_q      (words[i*WORD_W +: WORD_W]),
            .toggle_rst  (toggle_rst[i]),
            .frozen      (pipe_frozen[i]),
            .bank_switch (bank_switch[i]),
            .bank_sel    (bank_sel[i]),
            .pipe_irq    (pipe_irq[i])
        );
    end

    assign irq = |pipe_irq;

    a_r11_summary_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_irq == '0) |-> !irq);
endmodule

// File: tb/hpb_ctl_bank_test.sv
module hpb_ctl_bank_test;
    localparam int NP = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pipe_is_int = '1, cfg_ok = '1, stall_evt = '0, err_flag = '0;
    logic [NP-1:0] quota_done = '0, pipe_rst = '0, pipe_en = '0, bank_evt = '0;
    logic [NP*9-1:0] stat_flags = '0;
    logic [NP-1:0] toggle_rst, pipe_frozen, bank_switch, bank_sel, pipe_irq;
    logic irq;
    int n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    hpb_ctl_bank uut (.*);

    typedef struct packed {
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{8'h40, 32'h0000_00FF, 8'h00, 32'h0000_00FF},  // R3 set enables pipe0
        '{8'h80, 32'h0000_000F, 8'h00, 32'h0000_00F0},  // R4 partial clear
        '{8'h64, 32'h0001_1000, 8'h24, 32'h0001_1000},  // R3 pipe9 busy+dma
        '{8'h24, 32'hFFFF_FFFF, 8'h24, 32'h0001_1000},  // R4 read view write ignored
        '{8'h4C, 32'hFFFB_FFFF, 8'h0C, 32'h0003_10FF},  // R4 reserved read 0
        '{8'h8C, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0000},  // R4 clear all
        '{8'h68, 32'h0000_00FF, 8'h28, 32'h0000_0000},  // R2 index 10
        '{8'hC4, 32'h0000_00FF, 8'h04, 32'h0000_0000},  // R2 region 3
        '{8'h45, 32'h0000_00FF, 8'h04, 32'h0000_0000}   // R2 misaligned
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, edge passes, return at next negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h00, r); chk("R1 word pipe0", r, 32'h0);
        rd(8'h24, r); chk("R1 word pipe9", r, 32'h0);
        chk("R1 outputs", {toggle_rst, pipe_frozen, bank_switch}, 32'h0);
        chk("R1 bank_sel/irq", {bank_sel, pipe_irq, irq}, 32'h0);

        for (int k = 0; k < 9; k++) begin
            wr(VEC[k].waddr, VEC[k].wdata);
            rd(VEC[k].raddr, r);
            chk($sformatf("R2/R3/R4 vector %0d", k), r, VEC[k].exp);
        end

        // R5 non-interrupt pipe ignores writes
        pipe_is_int[2] = 1'b0;
        wr(8'h48, 32'h0000_00FF);
        rd(8'h08, r); chk("R5 gated write", r, 32'h0);
        pipe_is_int[2] = 1'b1;

        // R6 hardware freeze causes
        cfg_ok[1] = 1'b0; @(negedge clk); cfg_ok[1] = 1'b1;
        chk("R6 unconfigured freeze", 32'(pipe_frozen[1]), 32'h1);
        wr(8'h84, 32'h0002_0000);
        chk("R6 sw clear", 32'(pipe_frozen[1]), 32'h0);
        stall_evt[1] = 1'b1; @(negedge clk); stall_evt[1] = 1'b0;
        chk("R6 stall freeze", 32'(pipe_frozen[1]), 32'h1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h84; bus_wdata = 32'h0002_0000; err_flag[1] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; err_flag[1] = 1'b0;
        chk("R6 conflict hw wins", 32'(pipe_frozen[1]), 32'h1);
        wr(8'h84, 32'h0002_0000);
        quota_done[1] = 1'b1; @(negedge clk); quota_done[1] = 1'b0;
        chk("R6 quota freeze", 32'(pipe_frozen[1]), 32'h1);

        // R7 edge-only freeze
        pipe_en[4] = 1'b1; @(negedge clk);
        chk("R7 enable rise", 32'(pipe_frozen[4]), 32'h1);
        wr(8'h90, 32'h0002_0000);
        @(negedge clk);
        chk("R7 level held", 32'(pipe_frozen[4]), 32'h0);
        pipe_rst[4] = 1'b1; @(negedge clk);
        chk("R7 reset rise", 32'(pipe_frozen[4]), 32'h1);

        // R8 toggle reset pulse
        wr(8'h58, 32'h0004_0000);
        chk("R8 pulse high", 32'(toggle_rst[6]), 32'h1);
        @(negedge clk);
        chk("R8 pulse low", 32'(toggle_rst[6]), 32'h0);
        rd(8'h18, r); chk("R8 bit self-clear", r, 32'h0);

        // R9 grant and set-alias ignored
        wr(8'h5C, 32'h0000_4000);
        rd(8'h1C, r); chk("R9 set bit14 ignored", r, 32'h0);
        bank_evt[7] = 1'b1; @(negedge clk); bank_evt[7] = 1'b0;
        rd(8'h1C, r); chk("R9 grant", r, 32'h0000_4000);

        // R10 release
        wr(8'h9C, 32'h0000_4000);
        chk("R10 strobe", {31'b0, bank_switch[7]}, 32'h1);
        chk("R10 bank flip", {31'b0, bank_sel[7]}, 32'h1);
        @(negedge clk);
        chk("R10 strobe ends", {31'b0, bank_switch[7]}, 32'h0);
        wr(8'h9C, 32'h0000_4000);
        chk("R10 clear in wait", {bank_switch[7], bank_sel[7]}, 32'h1);
        bank_evt[7] = 1'b1; @(negedge clk); bank_evt[7] = 1'b0;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h9C; bus_wdata = 32'h0000_4000; bank_evt[7] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bank_evt[7] = 1'b0;
        chk("R10 conflict no strobe", {bank_switch[7], bank_sel[7]}, 32'h1);
        rd(8'h1C, r); chk("R10 conflict owned", r, 32'h0000_4000);

        // R11 interrupt combination
        wr(8'h60, 32'h0000_1010);
        stat_flags[8*9 +: 9] = 9'h020; #1;
        chk("R11 unenabled flag", {pipe_irq[8], irq}, 32'h0);
        stat_flags[8*9 +: 9] = 9'h010; #1;
        chk("R11 enabled flag", {pipe_irq[8], irq}, 32'h3);
        stat_flags[8*9 +: 9] = 9'h100; #1;
        chk("R11 busy flag", {pipe_irq[8], irq}, 32'h3);
        wr(8'hA0, 32'h0000_1000); #1;
        chk("R11 busy disabled", {pipe_irq[8], irq}, 32'h0);

        summary();
    end
endmodule